// File: doc/BRIEF.md
# SMBus Host Block-Data Buffer

This block sits behind the byte-wide block-data port of an SMBus host controller. In buffer mode it is a 32-entry byte store. Software fills it before a block write and drains it after a block read. Each access to the port uses a software index, and that index steps forward by one after every access. A read of the host control register, reported to this block as a one-cycle pulse, returns the index to zero. The block also holds data register 0, which carries the byte count of a block transfer, and a two-bit auxiliary control register. One bit of that register selects buffer mode and the other enables hardware PEC. The PEC bit is passed straight through to the transaction engine.

The transaction engine reaches the same storage through a second, independent pointer. On a block write it reads bytes from entry 0 upward and is told when the current byte is the last one the count covers. On a block read it first loads the received count into data register 0, then stores bytes from entry 0 upward. A count of zero or above 32 raises a length error, and no store ever goes past the last entry. When buffer mode is off, the port becomes a single holding byte that is exchanged with the engine under a per-byte done flag.

Top module: `smbuf_top`

## Requirements
- R1: Writing register select 2 (auxiliary control) stores wdata bit 1 as buffer mode and bit 0 as PEC enable. These drive `buf_mode` and `pec_en`, and a read of select 2 returns them in bits 1:0 with the upper bits zero. No other access changes either bit.
- R2: A one-cycle `hctl_rd` pulse returns the software index to 0, whatever accesses occur in the same cycle.
- R3: In buffer mode, each read or write strobe on register select 1 (block port) accesses the entry at the software index. The index then steps forward by one. A read returns the addressed entry in the same cycle.
- R4: Once the software index reaches 32 it stays there. Block-port reads return 0 and block-port writes change no entry.
- R5: Register select 0 is data register 0. Software may write it and read it back, and it drives `eng_count`. An `eng_cnt_we` pulse loads `eng_cnt_in` into it, and the engine wins when both write in the same cycle.
- R6: `eng_start` returns the engine pointer to 0. `eng_tx_byte` shows the entry at the engine pointer, `eng_pop` advances the pointer, and `eng_tx_last` is 1 exactly when the pointer plus one equals data register 0.
- R7: In buffer mode, `eng_push` stores `eng_rx_byte` at the engine pointer and advances it. The push is taken only while the pointer is below both data register 0 and 32. A refused push changes no entry.
- R8: An `eng_cnt_we` load of 0 or of a value above 32 sets `eng_len_err`, which stays set until the next `eng_start` that comes without a count load.
- R9: With buffer mode off, block-port accesses read and write one holding byte and leave the software index unchanged. `eng_push` loads the holding byte, `eng_tx_byte` shows it, and `eng_push` or `eng_pop` sets `hs_done`. `hs_clr` clears `hs_done`, and a set in the same cycle wins.
- R10: After reset, both auxiliary bits, data register 0, all entries, both pointers, `hs_done` and `eng_len_err` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_sel | input | 2 | Register select: 0 data register 0, 1 block port, 2 auxiliary control, 3 none |
| sw_wr | input | 1 | Software write strobe |
| sw_rd | input | 1 | Software read strobe |
| sw_wdata | input | 8 | Software write data |
| sw_rdata | output | 8 | Software read data for the selected register |
| hctl_rd | input | 1 | Pulse marking a read of the host control register |
| buf_mode | output | 1 | 32-entry buffer mode enabled |
| pec_en | output | 1 | Hardware PEC enable for the engine |
| eng_start | input | 1 | Engine begins a transfer; clears its pointer |
| eng_pop | input | 1 | Engine has consumed the transmit byte |
| eng_tx_byte | output | 8 | Byte offered to the engine |
| eng_tx_last | output | 1 | Transmit byte is the last one covered by the count |
| eng_cnt_we | input | 1 | Engine loads a received count |
| eng_cnt_in | input | 8 | Received count |
| eng_count | output | 8 | Contents of data register 0 |
| eng_push | input | 1 | Engine delivers a received byte |
| eng_rx_byte | input | 8 | Received byte |
| eng_len_err | output | 1 | Received count out of the range 1 to 32 |
| hs_done | output | 1 | Single-byte mode: byte exchanged |
| hs_clr | input | 1 | Clears hs_done |

## Verification
The bench writes 33 bytes and reads 34, then reads entry 0 again after an index reset. A design whose index wraps would overwrite entry 0 with the ignored 33rd byte or return stale data in place of zeros. Received counts of 3, 40 and 0 are aimed at the push guard and the error flag. A design that ignores the count would overwrite entry 3, and one that ignores the depth would store past the last entry. The single-byte mode is checked by switching back to buffer mode and reading entry 0, which shows whether holding-byte accesses stepped the index. Simultaneous software and engine writes to data register 0, and a done clear in the same cycle as a set, show whether the stated priorities hold.

// File: rtl/smbuf_pkg.sv
package smbuf_pkg;
   typedef enum logic [1:0] {
      SEL_DAT0 = 2'd0,
      SEL_BLK  = 2'd1,
      SEL_AUX  = 2'd2,
      SEL_IDLE = 2'd3
   } smbuf_sel_e;

   localparam int AUX_PEC_BIT = 0;
   localparam int AUX_BUF_BIT = 1;
   localparam int AUX_W       = 2;
endpackage

// File: rtl/smbuf_index.sv
// Saturating pointer: clear has priority, step stops at LIMIT.
module smbuf_index #(
   parameter int DEPTH = 32,
   parameter int IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   output logic [IDX_W-1:0] idx
);
   localparam logic [IDX_W-1:0] LIMIT = IDX_W'(DEPTH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idx <= '0;
      else if (clr)
         idx <= '0;
      else if (step && (idx < LIMIT))
         idx <= idx + IDX_W'(1);
   end
endmodule

// File: rtl/smbuf_store.sv
// Byte store with two write ports (port A wins) and two read ports.
module smbuf_store #(
   parameter int DATA_W         = 8,
   parameter int DEPTH          = 32,
   parameter int IDX_W          = 6,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wa_en,
   input  logic [IDX_W-1:0]  wa_addr,
   input  logic [DATA_W-1:0] wa_data,
   input  logic              wb_en,
   input  logic [IDX_W-1:0]  wb_addr,
   input  logic [DATA_W-1:0] wb_data,
   input  logic [IDX_W-1:0]  ra_addr,
   output logic [DATA_W-1:0] ra_data,
   input  logic [IDX_W-1:0]  rb_addr,
   output logic [DATA_W-1:0] rb_data
);
   localparam int               AW    = $clog2(DEPTH);
   localparam logic [IDX_W-1:0] LIMIT = IDX_W'(DEPTH);

   logic [DEPTH-1:0][DATA_W-1:0] flat;

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic              hit_a;
      logic              hit_b;
      logic [DATA_W-1:0] q;

      assign hit_a = wa_en && (wa_addr == IDX_W'(e));
      assign hit_b = wb_en && (wb_addr == IDX_W'(e));

      if (CLEAR_ON_RESET) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (hit_a)
               q <= wa_data;
            else if (hit_b)
               q <= wb_data;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (hit_a)
               q <= wa_data;
            else if (hit_b)
               q <= wb_data;
         end
      end

      assign flat[e] = q;
   end

   assign ra_data = (ra_addr < LIMIT) ? flat[ra_addr[AW-1:0]] : '0;
   assign rb_data = (rb_addr < LIMIT) ? flat[rb_addr[AW-1:0]] : '0;
endmodule

// File: rtl/smbuf_regs.sv
// Auxiliary control, data register 0, holding byte, done flag, length error.
module smbuf_regs
   import smbuf_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_aux,
   input  logic              wr_dat0,
   input  logic              wr_hold,
   input  logic [DATA_W-1:0] wdata,
   input  logic              cnt_we,
   input  logic [DATA_W-1:0] cnt_in,
   input  logic              eng_start,
   input  logic              eng_hold_we,
   input  logic [DATA_W-1:0] eng_rx_byte,
   input  logic              hs_set,
   input  logic              hs_clr,
   output logic [AUX_W-1:0]  aux_q,
   output logic [DATA_W-1:0] dat0_q,
   output logic [DATA_W-1:0] hold_q,
   output logic              hs_done,
   output logic              len_err
);
   localparam logic [DATA_W-1:0] MAX_LEN = DATA_W'(DEPTH);

   logic cnt_bad;
   assign cnt_bad = (cnt_in == '0) || (cnt_in > MAX_LEN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         aux_q   <= '0;
         dat0_q  <= '0;
         hold_q  <= '0;
         hs_done <= 1'b0;
         len_err <= 1'b0;
      end else begin
         if (wr_aux)
            aux_q <= wdata[AUX_W-1:0];

         if (cnt_we)
            dat0_q <= cnt_in;
         else if (wr_dat0)
            dat0_q <= wdata;

         if (eng_hold_we)
            hold_q <= eng_rx_byte;
         else if (wr_hold)
            hold_q <= wdata;

         if (hs_set)
            hs_done <= 1'b1;
         else if (hs_clr)
            hs_done <= 1'b0;

         if (cnt_we)
            len_err <= cnt_bad;
         else if (eng_start)
            len_err <= 1'b0;
      end
   end
endmodule

// File: rtl/smbuf_top.sv
module smbuf_top
   import smbuf_pkg::*;
#(
   parameter int DATA_W         = 8,
   parameter int DEPTH          = 32,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        sw_sel,
   input  logic              sw_wr,
   input  logic              sw_rd,
   input  logic [DATA_W-1:0] sw_wdata,
   output logic [DATA_W-1:0] sw_rdata,
   input  logic              hctl_rd,
   output logic              buf_mode,
   output logic              pec_en,
   input  logic              eng_start,
   input  logic              eng_pop,
   output logic [DATA_W-1:0] eng_tx_byte,
   output logic              eng_tx_last,
   input  logic              eng_cnt_we,
   input  logic [DATA_W-1:0] eng_cnt_in,
   output logic [DATA_W-1:0] eng_count,
   input  logic              eng_push,
   input  logic [DATA_W-1:0] eng_rx_byte,
   output logic              eng_len_err,
   output logic              hs_done,
   input  logic              hs_clr
);
   localparam int               IDX_W = $clog2(DEPTH + 1);
   localparam logic [IDX_W-1:0] LIMIT = IDX_W'(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("smbuf_top: DEPTH must be at least 2");
   end
   if (DEPTH >= (1 << DATA_W)) begin : g_bad_width
      $error("smbuf_top: DEPTH must fit in a DATA_W-bit count");
   end
   if (DATA_W <= IDX_W || DATA_W < AUX_W) begin : g_bad_data
      $error("smbuf_top: DATA_W too narrow for the index");
   end

   smbuf_sel_e        sel;
   logic              blk_acc;
   logic              sw_step;
   logic              sw_store_we;
   logic              eng_store_we;
   logic              eng_adv;
   logic [IDX_W-1:0]  sw_idx;
   logic [IDX_W-1:0]  eng_ptr;
   logic [DATA_W-1:0] eng_ptr_ext;
   logic [DATA_W-1:0] store_sw_q;
   logic [DATA_W-1:0] store_eng_q;
   logic [AUX_W-1:0]  aux_q;
   logic [DATA_W-1:0] dat0_q;
   logic [DATA_W-1:0] hold_q;

   assign sel         = smbuf_sel_e'(sw_sel);
   assign buf_mode    = aux_q[AUX_BUF_BIT];
   assign pec_en      = aux_q[AUX_PEC_BIT];
   assign eng_count   = dat0_q;
   assign eng_ptr_ext = {{(DATA_W-IDX_W){1'b0}}, eng_ptr};

   assign blk_acc      = (sel == SEL_BLK) && (sw_wr || sw_rd);
   assign sw_step      = buf_mode && blk_acc;
   assign sw_store_we  = buf_mode && (sel == SEL_BLK) && sw_wr;
   assign eng_store_we = buf_mode && eng_push && (eng_ptr < LIMIT) && (eng_ptr_ext < dat0_q);
   assign eng_adv      = buf_mode && (eng_pop || eng_store_we);

   smbuf_index #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_sw_idx (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (hctl_rd),
      .step (sw_step),
      .idx  (sw_idx)
   );

   smbuf_index #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_eng_idx (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (eng_start),
      .step (eng_adv),
      .idx  (eng_ptr)
   );

   smbuf_store #(
      .DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W), .CLEAR_ON_RESET(CLEAR_ON_RESET)
   ) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .wa_en  (eng_store_we),
      .wa_addr(eng_ptr),
      .wa_data(eng_rx_byte),
      .wb_en  (sw_store_we),
      .wb_addr(sw_idx),
      .wb_data(sw_wdata),
      .ra_addr(sw_idx),
      .ra_data(store_sw_q),
      .rb_addr(eng_ptr),
      .rb_data(store_eng_q)
   );

   smbuf_regs #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_aux     (sw_wr && (sel == SEL_AUX)),
      .wr_dat0    (sw_wr && (sel == SEL_DAT0)),
      .wr_hold    (!buf_mode && (sel == SEL_BLK) && sw_wr),
      .wdata      (sw_wdata),
      .cnt_we     (eng_cnt_we),
      .cnt_in     (eng_cnt_in),
      .eng_start  (eng_start),
      .eng_hold_we(!buf_mode && eng_push),
      .eng_rx_byte(eng_rx_byte),
      .hs_set     (!buf_mode && (eng_push || eng_pop)),
      .hs_clr     (hs_clr),
      .aux_q      (aux_q),
      .dat0_q     (dat0_q),
      .hold_q     (hold_q),
      .hs_done    (hs_done),
      .len_err    (eng_len_err)
   );

   always_comb begin
      unique case (sel)
         SEL_DAT0: sw_rdata = dat0_q;
         SEL_BLK:  sw_rdata = buf_mode ? store_sw_q : hold_q;
         SEL_AUX:  sw_rdata = {{(DATA_W-AUX_W){1'b0}}, aux_q};
         default:  sw_rdata = '0;
      endcase
   end

   assign eng_tx_byte = buf_mode ? store_eng_q : hold_q;
   assign eng_tx_last = buf_mode && ((eng_ptr_ext + DATA_W'(1)) == dat0_q);
endmodule

// File: rtl/smbuf_chk.sv
module smbuf_chk #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        sw_sel,
   input logic              sw_wr,
   input logic              sw_rd,
   input logic [DATA_W-1:0] sw_rdata,
   input logic              hctl_rd,
   input logic              buf_mode,
   input logic              pec_en,
   input logic              eng_push,
   input logic              eng_pop,
   input logic              eng_cnt_we,
   input logic [DATA_W-1:0] eng_cnt_in,
   input logic              eng_len_err,
   input logic              hs_done,
   input logic              hs_clr,
   input logic [$clog2(DEPTH+1)-1:0] sw_idx,
   input logic [$clog2(DEPTH+1)-1:0] eng_ptr
);
   localparam int                IDX_W   = $clog2(DEPTH + 1);
   localparam logic [IDX_W-1:0]  LIMIT   = IDX_W'(DEPTH);
   localparam logic [DATA_W-1:0] MAX_LEN = DATA_W'(DEPTH);
   localparam logic [1:0]        S_BLK   = 2'd1;
   localparam logic [1:0]        S_AUX   = 2'd2;

   AST_AUX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(sw_wr && sw_sel == S_AUX) |=> ($stable(buf_mode) && $stable(pec_en))); // R1
   AST_IDX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      hctl_rd |=> (sw_idx == '0)); // R2
   AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_mode && sw_sel == S_BLK && (sw_wr || sw_rd) && !hctl_rd && sw_idx < LIMIT)
      |=> (sw_idx == $past(sw_idx) + IDX_W'(1))); // R3
   AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      sw_idx <= LIMIT); // R4
   AST_BEYOND_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_mode && sw_sel == S_BLK && sw_idx == LIMIT) |-> (sw_rdata == '0)); // R4
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      eng_ptr <= LIMIT); // R7
   AST_LEN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_cnt_we && (eng_cnt_in == '0 || eng_cnt_in > MAX_LEN)) |=> eng_len_err); // R8
   AST_HS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (!buf_mode && (eng_push || eng_pop)) |=> hs_done); // R9
   AST_HS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_clr && !(!buf_mode && (eng_push || eng_pop))) |=> !hs_done); // R9
   AST_SINGLE_IDX: assert property (@(posedge clk) disable iff (!rst_n)
      (!buf_mode && !hctl_rd) |=> $stable(sw_idx)); // R9
endmodule

bind smbuf_top smbuf_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sw_sel     (sw_sel),
   .sw_wr      (sw_wr),
   .sw_rd      (sw_rd),
   .sw_rdata   (sw_rdata),
   .hctl_rd    (hctl_rd),
   .buf_mode   (buf_mode),
   .pec_en     (pec_en),
   .eng_push   (eng_push),
   .eng_pop    (eng_pop),
   .eng_cnt_we (eng_cnt_we),
   .eng_cnt_in (eng_cnt_in),
   .eng_len_err(eng_len_err),
   .hs_done    (hs_done),
   .hs_clr     (hs_clr),
   .sw_idx     (sw_idx),
   .eng_ptr    (eng_ptr)
);

// File: tb/tb_smbuf_top.sv
module tb_smbuf_top;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] sw_sel = 2'd3;
   logic       sw_wr = 1'b0, sw_rd = 1'b0;
   logic [7:0] sw_wdata = '0;
   logic [7:0] sw_rdata;
   logic       hctl_rd = 1'b0;
   logic       buf_mode, pec_en;
   logic       eng_start = 1'b0, eng_pop = 1'b0, eng_cnt_we = 1'b0, eng_push = 1'b0;
   logic [7:0] eng_tx_byte, eng_count;
   logic       eng_tx_last, eng_len_err, hs_done;
   logic [7:0] eng_cnt_in = '0, eng_rx_byte = '0;
   logic       hs_clr = 1'b0;

   int checks = 0;
   int errors = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   smbuf_top dut (
      .clk(clk), .rst_n(rst_n), .sw_sel(sw_sel), .sw_wr(sw_wr), .sw_rd(sw_rd),
      .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .hctl_rd(hctl_rd),
      .buf_mode(buf_mode), .pec_en(pec_en), .eng_start(eng_start), .eng_pop(eng_pop),
      .eng_tx_byte(eng_tx_byte), .eng_tx_last(eng_tx_last), .eng_cnt_we(eng_cnt_we),
      .eng_cnt_in(eng_cnt_in), .eng_count(eng_count), .eng_push(eng_push),
      .eng_rx_byte(eng_rx_byte), .eng_len_err(eng_len_err), .hs_done(hs_done),
      .hs_clr(hs_clr)
   );

   task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Monitor: pops expected read data and compares while the strobe is held.
   always @(negedge clk) begin
      #(CLK_PERIOD/4);
      if (rst_n && sw_rd) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL scoreboard: actual %h expected none", sw_rdata);
         end else begin
            check8(tag_q.pop_front(), sw_rdata, exp_q.pop_front());
         end
      end
   end

   task automatic sw_write(logic [1:0] s, logic [7:0] d);
      @(negedge clk); sw_sel = s; sw_wdata = d; sw_wr = 1'b1;
      @(posedge clk); #1; sw_wr = 1'b0; sw_sel = 2'd3;
   endtask

   task automatic sw_read(logic [1:0] s, logic [7:0] exp, string tag);
      @(negedge clk); sw_sel = s; sw_rd = 1'b1;
      exp_q.push_back(exp); tag_q.push_back(tag);
      @(posedge clk); #1; sw_rd = 1'b0; sw_sel = 2'd3;
   endtask

   task automatic hctl_pulse();
      @(negedge clk); hctl_rd = 1'b1;
      @(posedge clk); #1; hctl_rd = 1'b0;
   endtask

   task automatic eng_op(bit st, bit pop, bit cwe, logic [7:0] cnt, bit push,
                         logic [7:0] rx, bit clr);
      @(negedge clk);
      eng_start = st; eng_pop = pop; eng_cnt_we = cwe; eng_cnt_in = cnt;
      eng_push = push; eng_rx_byte = rx; hs_clr = clr;
      @(posedge clk); #1;
      eng_start = 0; eng_pop = 0; eng_cnt_we = 0; eng_push = 0; hs_clr = 0;
   endtask

   task automatic settle();
      @(negedge clk); #1;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      settle();
      // R10 reset state
      check8("R10 buf_mode", {7'b0, buf_mode}, 8'h00);
      check8("R10 pec_en", {7'b0, pec_en}, 8'h00);
      check8("R10 count", eng_count, 8'h00);
      check8("R10 hs_done", {7'b0, hs_done}, 8'h00);
      check8("R10 len_err", {7'b0, eng_len_err}, 8'h00);
      sw_read(2'd2, 8'h00, "R10 aux read");
      sw_read(2'd1, 8'h00, "R10 holding byte");

      // R1 auxiliary control
      sw_write(2'd2, 8'hFF);
      settle();
      check8("R1 buf_mode", {7'b0, buf_mode}, 8'h01);
      check8("R1 pec_en", {7'b0, pec_en}, 8'h01);
      sw_read(2'd2, 8'h03, "R1 aux upper bits zero");
      sw_write(2'd2, 8'h02);
      sw_write(2'd0, 8'hFF);
      settle();
      check8("R1 pec off, unchanged by other write", {6'b0, buf_mode, pec_en}, 8'h02);

      // R3/R4 fill beyond the end
      hctl_pulse();
      for (int i = 0; i < 32; i++) sw_write(2'd1, 8'h10 + 8'(i));
      sw_write(2'd1, 8'hEE);
      hctl_pulse();
      for (int i = 0; i < 32; i++) sw_read(2'd1, 8'h10 + 8'(i), "R3 sequential read");
      sw_read(2'd1, 8'h00, "R4 read past end");
      sw_read(2'd1, 8'h00, "R4 read past end again");
      hctl_pulse();
      sw_read(2'd1, 8'h10, "R2 index reset, R4 no wrap onto entry 0");

      // R5 data register 0
      sw_write(2'd0, 8'h05);
      sw_read(2'd0, 8'h05, "R5 count readback");
      settle();
      check8("R5 eng_count", eng_count, 8'h05);

      // R6 engine transmit path
      eng_op(1, 0, 0, 0, 0, 0, 0);
      settle();
      check8("R6 first tx byte", eng_tx_byte, 8'h10);
      check8("R6 not last", {7'b0, eng_tx_last}, 8'h00);
      for (int i = 0; i < 4; i++) eng_op(0, 1, 0, 0, 0, 0, 0);
      settle();
      check8("R6 fifth tx byte", eng_tx_byte, 8'h14);
      check8("R6 last flag", {7'b0, eng_tx_last}, 8'h01);

      // R7 engine receive path, count 3
      eng_op(1, 0, 0, 0, 0, 0, 0);
      eng_op(0, 0, 1, 8'd3, 0, 0, 0);
      settle();
      check8("R8 valid count no error", {7'b0, eng_len_err}, 8'h00);
      for (int i = 0; i < 4; i++) eng_op(0, 0, 0, 0, 1, 8'hA0 + 8'(i), 0);
      hctl_pulse();
      sw_read(2'd1, 8'hA0, "R7 rx byte 0");
      sw_read(2'd1, 8'hA1, "R7 rx byte 1");
      sw_read(2'd1, 8'hA2, "R7 rx byte 2");
      sw_read(2'd1, 8'h13, "R7 push beyond count refused");
      sw_read(2'd0, 8'h03, "R5 engine-loaded count");

      // R8 oversize count
      eng_op(1, 0, 0, 0, 0, 0, 0);
      eng_op(0, 0, 1, 8'd40, 0, 0, 0);
      settle();
      check8("R8 count 40 error", {7'b0, eng_len_err}, 8'h01);
      for (int i = 0; i < 33; i++) eng_op(0, 0, 0, 0, 1, 8'hB0 + 8'(i), 0);
      hctl_pulse();
      for (int i = 0; i < 32; i++) sw_read(2'd1, 8'hB0 + 8'(i), "R7 bounded rx byte");
      sw_read(2'd1, 8'h00, "R7 no overflow past last entry");
      eng_op(1, 0, 0, 0, 0, 0, 0);
      settle();
      check8("R8 cleared by start", {7'b0, eng_len_err}, 8'h00);
      eng_op(0, 0, 1, 8'd0, 0, 0, 0);
      settle();
      check8("R8 zero count error", {7'b0, eng_len_err}, 8'h01);
      eng_op(1, 0, 0, 0, 0, 0, 0);

      // R5 engine wins over software
      @(negedge clk);
      sw_sel = 2'd0; sw_wdata = 8'h09; sw_wr = 1'b1; eng_cnt_we = 1'b1; eng_cnt_in = 8'h07;
      @(posedge clk); #1;
      sw_wr = 1'b0; sw_sel = 2'd3; eng_cnt_we = 1'b0;
      sw_read(2'd0, 8'h07, "R5 engine priority");

      // R9 single-byte mode
      sw_write(2'd2, 8'h00);
      hctl_pulse();
      sw_write(2'd1, 8'h5A);
      sw_read(2'd1, 8'h5A, "R9 holding byte readback");
      sw_read(2'd1, 8'h5A, "R9 holding byte stable");
      settle();
      check8("R9 tx holding byte", eng_tx_byte, 8'h5A);
      sw_write(2'd2, 8'h02);
      sw_read(2'd1, 8'hB0, "R9 index untouched in single mode");
      sw_write(2'd2, 8'h00);
      eng_op(0, 0, 0, 0, 1, 8'h77, 0);
      settle();
      check8("R9 push sets done", {7'b0, hs_done}, 8'h01);
      sw_read(2'd1, 8'h77, "R9 engine loaded holding byte");
      eng_op(0, 0, 0, 0, 0, 0, 1);
      settle();
      check8("R9 clear", {7'b0, hs_done}, 8'h00);
      eng_op(0, 1, 0, 0, 0, 0, 0);
      settle();
      check8("R9 pop sets done", {7'b0, hs_done}, 8'h01);
      eng_op(0, 0, 0, 0, 0, 0, 1);
      eng_op(0, 0, 0, 0, 1, 8'h33, 1);
      settle();
      check8("R9 set wins over clear", {7'b0, hs_done}, 8'h01);

      repeat (2) @(negedge clk);
      if (exp_q.size() != 0) begin
         checks++; errors++;
         $display("FAIL scoreboard drain: actual %0d expected 0", exp_q.size());
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule